// File: doc/BRIEF.md
# Dual-Style Multiplexed Host Register Port

This block is the slave side of an 8-bit host bus that carries address and data on the same lines. A microcontroller selects the block with an active-low chip select, puts a register address on the shared lines, pulses an address strobe, and then runs a data phase that either reads or writes one register in a small internal bank. The block also drives an active-low wait line for a fixed number of clocks at the start of every data phase.

The convention for the data phase is set by a static style pin. When the pin is high, one active-low data strobe marks the phase, and a direction level gives its type: 1 means read, 0 means write. When the pin is low, separate active-low read and write strobes mark the phase. In each style, the strobes that belong to the other style are ignored. Every bus input passes through a two-flop synchronizer into the block clock before any edge is detected. The shared lines are modelled as separate input, output and output-enable signals.

Top module: `mux_host_port`

## Requirements
- R1: After reset, wait_n is 1, ad_oe is 0, the latched address is 0, and every register reads 0.
- R2: A rising ale while cs_n is low latches the lines ad_in[3:0] as the register address. A rising ale while cs_n is high leaves the latched address unchanged.
- R3: With style_sel=1, a data phase lasts while ds_n=0. It reads when rw=1 and writes when rw=0. rd_n and wr_n have no effect.
- R4: With style_sel=0, rd_n=0 marks a read phase and wr_n=0 marks a write phase. ds_n and rw have no effect, and they do not assert wait_n.
- R5: ad_oe is 1 only during a read phase with cs_n low. While ad_oe is 1, ad_out carries the addressed register.
- R6: When a data phase starts with cs_n low, wait_n goes low on the third rising clock edge after the strobe asserts. It stays low for exactly 2 cycles and then returns high.
- R7: A write stores the value on ad_in as seen when the strobe deasserts, not the value present when it asserted. A later read returns the stored value.
- R8: A data phase with cs_n high writes nothing, does not drive ad_oe, and does not assert wait_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| style_sel | input | 1 | 1: data strobe plus direction level; 0: separate read and write strobes |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address strobe, active high |
| ds_n | input | 1 | Data strobe, active low (style 1) |
| rw | input | 1 | Direction level, 1 = read (style 1) |
| rd_n | input | 1 | Read strobe, active low (style 0) |
| wr_n | input | 1 | Write strobe, active low (style 0) |
| ad_in | input | 8 | Multiplexed address/data lines, input side |
| ad_out | output | 8 | Read data, output side |
| ad_oe | output | 1 | Output driver enable for the shared lines |
| wait_n | output | 1 | Wait, active low |

## Verification
The assertions check four things on every cycle. The latched address moves only on a qualified address-strobe edge. The wait pulse never starts without chip select and never exceeds its length. The read data does not change without a write. A wait pulse lasts at least two cycles. Only the directed scenarios can show the rest: that each style ignores the other style's strobes, that a write keeps the data present at strobe release, and that a phase with chip select high leaves the bank untouched. They also show the exact cycle on which wait falls after synchronization.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the multiplexed host port.
// Assumes: style pin encoding 1 = strobe plus direction, 0 = split strobes.
package hbus_pkg;
    typedef enum logic {
        STYLE_SPLIT = 1'b0,
        STYLE_DIR   = 1'b1
    } bus_style_e;

    // Decoded data-phase request from either style.
    typedef struct packed {
        logic active;
        logic is_read;
    } phase_req_t;
endpackage

// File: rtl/hbus_sync.sv
`timescale 1ns/1ps
// Module: hbus_sync
// Brings an asynchronous bus vector into the clock domain through STAGES flops.
// Assumes: each bit is sampled on its own; the host holds levels for several clocks.
module hbus_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop rank of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[g] <= RST_VAL;
                else if (g == 0) stage[g] <= d;
                else stage[g] <= stage[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hbus_strobe_dec.sv
`timescale 1ns/1ps
// Module: hbus_strobe_dec
// Maps the strobes of the selected bus style to one data-phase request.
// Assumes: inputs are already synchronized; the other style's strobes are ignored.
module hbus_strobe_dec
    import hbus_pkg::*;
(
    input  logic       style_sel,
    input  logic       ds_n,
    input  logic       rw,
    input  logic       rd_n,
    input  logic       wr_n,
    output phase_req_t req
);
    // Select the active convention; a read strobe wins if both split strobes are low.
    always_comb begin
        if (bus_style_e'(style_sel) == STYLE_DIR) begin
            req.active  = ~ds_n;
            req.is_read = rw;
        end else begin
            req.active  = ~rd_n | ~wr_n;
            req.is_read = ~rd_n;
        end
    end
endmodule

// File: rtl/hbus_regbank.sv
`timescale 1ns/1ps
// Module: hbus_regbank
// Register bank with one synchronous write port and one combinational read port.
// Assumes: a single writer; all entries clear on reset.
module hbus_regbank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store on a write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (rdata == $past(rdata)) || (addr != $past(addr))); // R7
endmodule

// File: rtl/mux_host_port.sv
`timescale 1ns/1ps
// Module: mux_host_port
// Slave port for a host bus that shares address and data lines. It latches an
// address on the address strobe, then runs one read or write per data phase in
// either strobe style, with a fixed-length wait pulse.
// Assumes: style_sel is static; the host holds each level for several clocks.
module mux_host_port
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_sel,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              wait_n
);
    localparam int SW = DATA_W + 6;
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [SW-1:0] SYNC_RST = {6'b101011, {DATA_W{1'b0}}};

    logic [SW-1:0]     raw_v, syn_v;
    logic              cs_s_n, ale_s, ds_s_n, rw_s, rd_s_n, wr_s_n;
    logic [DATA_W-1:0] ad_s;
    phase_req_t        req;
    logic              ale_q, act_q, ale_rise, act_rise, act_fall;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_pend, we;
    logic [CW-1:0]     wait_cnt;
    logic [DATA_W-1:0] rd_data;

    assign raw_v = {cs_n, ale, ds_n, rw, rd_n, wr_n, ad_in};

    hbus_sync #(.W(SW), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
    );

    assign {cs_s_n, ale_s, ds_s_n, rw_s, rd_s_n, wr_s_n, ad_s} = syn_v;

    hbus_strobe_dec u_dec (
        .style_sel(style_sel), .ds_n(ds_s_n), .rw(rw_s),
        .rd_n(rd_s_n), .wr_n(wr_s_n), .req(req)
    );

    // Previous-cycle copies of the synchronized strobes, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            act_q <= 1'b0;
        end else begin
            ale_q <= ale_s;
            act_q <= req.active;
        end
    end

    assign ale_rise = ale_s & ~ale_q;
    assign act_rise = req.active & ~act_q;
    assign act_fall = ~req.active & act_q;

    // Latch the register address on a qualified address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr_q <= '0;
        else if (ale_rise && !cs_s_n) addr_q <= ad_s[ADDR_W-1:0];
    end

    // Track a selected write phase until its strobe releases.
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_pend <= 1'b0;
        else if (act_rise) wr_pend <= !cs_s_n && !req.is_read;
        else if (act_fall) wr_pend <= 1'b0;
    end

    assign we = act_fall && wr_pend && !cs_s_n;

    // Count down the wait pulse from each selected phase start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wait_cnt <= '0;
        else if (act_rise && !cs_s_n) wait_cnt <= CW'(WAIT_CYC);
        else if (wait_cnt != '0)     wait_cnt <= wait_cnt - 1'b1;
    end

    hbus_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr_q),
        .wdata(ad_s), .rdata(rd_data)
    );

    assign wait_n = (wait_cnt == '0);
    assign ad_oe  = !cs_s_n && req.active && req.is_read;
    assign ad_out = rd_data;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_rise && !cs_s_n) |=> $stable(addr_q)); // R2
    AST_WAIT_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(!cs_s_n)); // R8
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CW'(WAIT_CYC)); // R6
    generate
        if (WAIT_CYC >= 2) begin : g_wait_min
            AST_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(wait_n) |=> !wait_n); // R6
        end
    endgenerate
endmodule

// File: tb/sim_mux_host_port.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_mux_host_port;
    logic       clk = 1'b0;
    logic       rst_n, style_sel, cs_n, ale, ds_n, rw, rd_n, wr_n;
    logic [7:0] ad_in, ad_out;
    logic       ad_oe, wait_n;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    mux_host_port u0 (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .cs_n(cs_n),
        .ale(ale), .ds_n(ds_n), .rw(rw), .rd_n(rd_n), .wr_n(wr_n),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .wait_n(wait_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_addr(input logic [7:0] a);
        ad_in = a; ale = 1'b1; cyc(3); ale = 1'b0; cyc(3);
    endtask

    task automatic strobe_on(input logic rd);
        if (style_sel) begin rw = rd; ds_n = 1'b0; end
        else if (rd) rd_n = 1'b0;
        else wr_n = 1'b0;
    endtask

    task automatic strobe_off();
        ds_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rw = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        ad_in = d; strobe_on(1'b0); cyc(5); strobe_off(); cyc(4);
    endtask

    task automatic do_read(output logic [7:0] d, output logic oe);
        strobe_on(1'b1); cyc(5); d = ad_out; oe = ad_oe; strobe_off(); cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        chk("R1 wait_n", 8'(wait_n), 8'h1);
        chk("R1 ad_oe", 8'(ad_oe), 8'h0);
        style_sel = 1'b1; cs_n = 1'b0;
        do_read(d, oe);
        chk("R1 reg0 after reset", d, 8'h00);
        do_addr(8'h09); do_read(d, oe);
        chk("R1 reg9 after reset", d, 8'h00);
    endtask

    task automatic t_dir_style();
        logic [7:0] d; logic oe;
        style_sel = 1'b1; cs_n = 1'b0;
        do_addr(8'h03); do_write(8'hA5); do_read(d, oe);
        chk("R3 dir-style readback", d, 8'hA5);
        chk("R5 oe during read", 8'(oe), 8'h1);
        chk("R5 oe idle", 8'(ad_oe), 8'h0);
    endtask

    task automatic t_split_style();
        logic [7:0] d; logic oe;
        style_sel = 1'b0; cs_n = 1'b0;
        do_addr(8'h07); do_write(8'h5A); do_read(d, oe);
        chk("R4 split-style readback", d, 8'h5A);
        chk("R5 oe split read", 8'(oe), 8'h1);
        do_addr(8'h03); do_read(d, oe);
        chk("R2 other address kept", d, 8'hA5);
    endtask

    task automatic t_ignore_other();
        logic [7:0] d; logic oe; logic saw_wait;
        style_sel = 1'b1; cs_n = 1'b0; do_addr(8'h07);
        ad_in = 8'hFF; wr_n = 1'b0; saw_wait = 1'b0;
        for (int i = 0; i < 6; i++) begin cyc(1); if (!wait_n || ad_oe) saw_wait = 1'b1; end
        wr_n = 1'b1; rd_n = 1'b0; cyc(4);
        chk("R3 split strobes ignored, no oe", 8'(ad_oe), 8'h0);
        rd_n = 1'b1; cyc(4);
        chk("R3 split strobes ignored, no wait", 8'(saw_wait), 8'h0);
        do_read(d, oe);
        chk("R3 wr_n ignored in dir style", d, 8'h5A);
        style_sel = 1'b0; ad_in = 8'hEE; rw = 1'b0; ds_n = 1'b0; saw_wait = 1'b0;
        for (int i = 0; i < 6; i++) begin cyc(1); if (!wait_n) saw_wait = 1'b1; end
        ds_n = 1'b1; cyc(4);
        chk("R4 ds_n gives no wait in split style", 8'(saw_wait), 8'h0);
        do_read(d, oe);
        chk("R4 ds_n ignored in split style", d, 8'h5A);
    endtask

    task automatic t_addr_cs();
        logic [7:0] d; logic oe;
        style_sel = 1'b1; cs_n = 1'b0; do_addr(8'h07);
        cs_n = 1'b1; cyc(3); do_addr(8'h03); cs_n = 1'b0; cyc(3);
        do_read(d, oe);
        chk("R2 ale ignored with cs_n high", d, 8'h5A);
    endtask

    task automatic t_cs_high();
        logic [7:0] d; logic oe; logic seen;
        style_sel = 1'b1; cs_n = 1'b0; do_addr(8'h07);
        cs_n = 1'b1; cyc(3); seen = 1'b0;
        ad_in = 8'h11; strobe_on(1'b0);
        for (int i = 0; i < 5; i++) begin cyc(1); if (!wait_n) seen = 1'b1; end
        strobe_off(); cyc(4);
        strobe_on(1'b1);
        for (int i = 0; i < 5; i++) begin cyc(1); if (!wait_n || ad_oe) seen = 1'b1; end
        strobe_off(); cyc(4);
        chk("R8 no wait/oe when deselected", 8'(seen), 8'h0);
        cs_n = 1'b0; cyc(3); do_read(d, oe);
        chk("R8 no write when deselected", d, 8'h5A);
    endtask

    task automatic t_wait_timing();
        logic [5:0] prof;
        style_sel = 1'b0; cs_n = 1'b0; do_addr(8'h07);
        strobe_on(1'b1);
        for (int i = 0; i < 6; i++) begin cyc(1); prof[i] = wait_n; end
        strobe_off(); cyc(4);
        chk("R6 wait profile", 8'(prof), 8'h33);
    endtask

    task automatic t_write_release();
        logic [7:0] d; logic oe;
        style_sel = 1'b1; cs_n = 1'b0; do_addr(8'h0C);
        ad_in = 8'h22; strobe_on(1'b0); cyc(4);
        ad_in = 8'h33; cyc(4); strobe_off(); cyc(4);
        do_read(d, oe);
        chk("R7 data taken at release", d, 8'h33);
    endtask

    initial begin
        rst_n = 1'b0; style_sel = 1'b1; cs_n = 1'b1; ale = 1'b0;
        ds_n = 1'b1; rw = 1'b0; rd_n = 1'b1; wr_n = 1'b1; ad_in = 8'h00;
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset();
        t_dir_style();
        t_split_style();
        t_ignore_other();
        t_addr_cs();
        t_cs_high();
        t_wait_timing();
        t_write_release();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule